// File: doc/BRIEF.md
# Multi-Mode Programmable Interrupt Controller

This block collects up to 32 external interrupt lines from peripherals and turns them into a single interrupt request for a small processor core. Each line owns one bit in a pending register and one bit in an enable register. Software reaches both registers over a simple special-register bus: a write strobe, an address, 32 bits of write data and 32 bits of read data. The read data follows the address in the same cycle.

The way a line sets its pending bit is fixed when the block is built, and so is the way software acknowledges it. Three schemes are available. In edge mode a rising edge sets the bit and software clears it by writing a one. In level mode the bit simply tracks the line, so the device clears it by lowering the line. In latched-level mode the bit is held until the line is low and software also writes a zero. The request toward the core is registered. It is high whenever any pending bit is also enabled.

Top module: `pic_top`

## Requirements
- R1: While reset is asserted and directly after it, the pending register and the enable register read as zero and the interrupt request output is low.
- R2: When no trigger mode is given at build time, the block behaves in edge mode.
- R3: In edge mode, a pending bit becomes 1 in the cycle after its input line is sampled high, when the sample before was low.
- R4: In edge mode, a bus write to the pending register clears every bit where the write data holds 1. Bits where the write data holds 0 keep their value. A rising edge in the same cycle as a clearing write leaves the bit set.
- R5: In level mode, the pending register equals the input lines sampled one cycle earlier. Writes to the pending register have no effect.
- R6: In latched-level mode, a pending bit becomes 1 whenever its line is sampled high. A write of 0 to that bit clears it only when the line is low in the same cycle. A write of 1 has no effect, and lowering the line without a write leaves the bit set.
- R7: With the bus address equal to STATUS_ADDR, the read data shows the pending register. With it equal to MASK_ADDR, the read data shows the enable register. Any other address reads as zero.
- R8: The interrupt request output is, one cycle later, the OR of all bits of the pending register ANDed with the enable register.
- R9: Read-data bits at positions NUM_LINES and above are always zero. A bus write changes a register only when the write strobe is high and the address matches that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | External interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the current address |
| irq_req | output | 1 | Interrupt request toward the core |

## Verification
The hardest situations to reach are the cycle collisions between a line transition and a software write. Examples are a rising edge arriving in exactly the cycle that software writes a 1 to acknowledge the same bit, and a latched-level write of 0 landing while the line is still high. Random line toggles mixed with random writes hit these collisions only now and then. The bench therefore also walks a directed sequence that first drives every instance to a known all-zero state and then times each line change against each write. Three instances share one stimulus, one for each mode and each with a different line count, so every write and every edge is judged under all three acknowledge rules at once.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        TRIG_EDGE    = 2'd0,
        TRIG_LEVEL   = 2'd1,
        TRIG_LATCHED = 2'd2
    } trig_mode_e;

    localparam int unsigned BUS_W = 32;

    // Bits 0..n-1 set, the rest clear.
    function automatic logic [BUS_W-1:0] used_bits(input int unsigned n);
        if (n >= BUS_W) return '1;
        return (BUS_W'(1) << n) - BUS_W'(1);
    endfunction

endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] rise
);
    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines;
        rise      = lines & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pic_status.sv
module pic_status
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter trig_mode_e  MODE      = TRIG_EDGE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] status
);
    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
    } status_state_t;

    status_state_t st_d, st_q;

    generate
        if (MODE == TRIG_EDGE) begin : g_edge
            logic [NUM_LINES-1:0] rise;
            logic [NUM_LINES-1:0] ack;

            pic_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .lines (lines),
                .rise  (rise)
            );

            always_comb begin
                ack       = wr_en ? wdata : '0;
                st_d      = st_q;
                // A fresh edge wins over an acknowledge in the same cycle.
                st_d.pend = (st_q.pend & ~ack) | rise;
            end
        end else if (MODE == TRIG_LEVEL) begin : g_level
            wire unused_level = &{1'b0, wr_en, wdata};

            always_comb begin
                st_d      = st_q;
                st_d.pend = lines;
            end
        end else begin : g_latched
            logic [NUM_LINES-1:0] drop;

            always_comb begin
                // Cleared only by a zero write while the line is already low.
                drop      = wr_en ? (~wdata & ~lines) : '0;
                st_d      = st_q;
                st_d.pend = lines | (st_q.pend & ~drop);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.pend;
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned             NUM_LINES   = 32,
    parameter int unsigned             ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]       STATUS_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0]       MASK_ADDR   = 16'h0011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] status,
    output logic                 status_wr,
    output logic [NUM_LINES-1:0] mask,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 irq_req
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic                 irq;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        hit_status;
    logic        hit_mask;

    always_comb begin
        hit_status = (bus_addr == STATUS_ADDR);
        hit_mask   = (bus_addr == MASK_ADDR);
        status_wr  = bus_we && hit_status;

        st_d       = st_q;
        if (bus_we && hit_mask) st_d.mask = wdata;
        st_d.irq   = |(status & st_q.mask);

        bus_rdata  = '0;
        if (hit_status)    bus_rdata[NUM_LINES-1:0] = status;
        else if (hit_mask) bus_rdata[NUM_LINES-1:0] = st_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask    = st_q.mask;
    assign irq_req = st_q.irq;
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int unsigned       NUM_LINES   = 32,
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 16'h0011,
    parameter trig_mode_e        MODE        = TRIG_EDGE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_req
);
    logic [NUM_LINES-1:0] status_w;
    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] wdata_w;
    logic                 status_wr;

    assign wdata_w = bus_wdata[NUM_LINES-1:0];

    generate
        if (NUM_LINES < BUS_W) begin : g_narrow
            wire unused_wdata_hi = &{1'b0, bus_wdata[BUS_W-1:NUM_LINES]};
        end
    endgenerate

    pic_status #(
        .NUM_LINES (NUM_LINES),
        .MODE      (MODE)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (irq_lines),
        .wr_en  (status_wr),
        .wdata  (wdata_w),
        .status (status_w)
    );

    pic_regs #(
        .NUM_LINES   (NUM_LINES),
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .MASK_ADDR   (MASK_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wdata     (wdata_w),
        .status    (status_w),
        .status_wr (status_wr),
        .mask      (mask_w),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int unsigned       NUM_LINES   = 32,
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h0010,
    parameter trig_mode_e        MODE        = TRIG_EDGE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 irq_req,
    input logic [NUM_LINES-1:0] status_w,
    input logic [NUM_LINES-1:0] mask_w
);
    localparam logic [31:0] USED = used_bits(NUM_LINES);

    logic [1:0]           age_q;
    logic [NUM_LINES-1:0] l1_q, l2_q, wd1_q, rise_c;
    logic                 wr1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
            l1_q  <= '0;
            l2_q  <= '0;
            wd1_q <= '0;
            wr1_q <= 1'b0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            l1_q  <= irq_lines;
            l2_q  <= l1_q;
            wd1_q <= bus_wdata[NUM_LINES-1:0];
            wr1_q <= bus_we && (bus_addr == STATUS_ADDR);
        end
    end

    assign rise_c = l1_q & ~l2_q;

    assert_rdata_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~USED) == 32'd0);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> (irq_req == $past(|(status_w & mask_w))));

    generate
        if (MODE == TRIG_EDGE) begin : g_edge_chk
            assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> ((status_w & rise_c) == rise_c));
            assert_edge_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2 && wr1_q) |-> ((status_w & wd1_q & ~rise_c) == '0));
        end else if (MODE == TRIG_LEVEL) begin : g_level_chk
            assert_level_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> (status_w == l1_q));
        end else begin : g_latched_chk
            assert_latched_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> ((status_w & l1_q) == l1_q));
        end
    endgenerate
endmodule

bind pic_top pic_checker #(
    .NUM_LINES   (NUM_LINES),
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .MODE        (MODE)
) u_pic_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .status_w  (status_w),
    .mask_w    (mask_w)
);

// File: tb/pic_top_bench.sv
`timescale 1ns/1ps
module pic_top_bench;
    localparam logic [15:0] ST = 16'h0010;
    localparam logic [15:0] MK = 16'h0011;
    localparam logic [31:0] UE = 32'hFFFF_FFFF;
    localparam logic [31:0] UV = 32'h0000_00FF;
    localparam logic [31:0] UL = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = ST;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_e, rd_v, rd_l;
    logic        irq_e, irq_v, irq_l;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    // Edge instance relies on the default mode (R2).
    pic_top #(.NUM_LINES(32)) u_pic_top (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_e), .irq_req(irq_e));

    pic_top #(.NUM_LINES(8), .MODE(pic_pkg::TRIG_LEVEL)) u_pic_top_lvl (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines[7:0]), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_v), .irq_req(irq_v));

    pic_top #(.NUM_LINES(12), .MODE(pic_pkg::TRIG_LATCHED)) u_pic_top_lat (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines[11:0]), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_l), .irq_req(irq_l));

    // Reference state
    logic [31:0] ms_e = '0, mp_e = '0, mk_e = '0;
    logic [31:0] ms_v = '0, mk_v = '0;
    logic [31:0] ms_l = '0, mk_l = '0;
    logic        mi_e = 0, mi_v = 0, mi_l = 0;

    function automatic logic [31:0] exp_read(input logic [15:0] a, input logic [31:0] s,
                                             input logic [31:0] m);
        if (a == ST) return s;
        if (a == MK) return m;
        return 32'd0;
    endfunction

    function automatic logic [31:0] next_edge(input logic [31:0] s, input logic [31:0] p,
                                              input logic [31:0] ln, input logic wr,
                                              input logic [31:0] wd);
        return (s & ~(wr ? wd : 32'd0)) | (ln & ~p);
    endfunction

    function automatic logic [31:0] next_latched(input logic [31:0] s, input logic [31:0] ln,
                                                 input logic wr, input logic [31:0] wd);
        return ((ln & UL) | (s & ~(wr ? (~wd & ~ln) : 32'd0))) & UL;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step(input logic [31:0] ln, input logic we, input logic [15:0] ad,
                        input logic [31:0] wd);
        logic sw, kw;
        lines = ln; bus_we = we; bus_addr = ad; bus_wdata = wd;
        @(posedge clk);
        sw = we && (ad == ST);
        kw = we && (ad == MK);
        mi_e = |(ms_e & mk_e);
        mi_v = |(ms_v & mk_v);
        mi_l = |(ms_l & mk_l);
        ms_e = next_edge(ms_e, mp_e, ln, sw, wd);
        mp_e = ln;
        ms_v = ln & UV;
        ms_l = next_latched(ms_l, ln, sw, wd);
        if (kw) begin
            mk_e = wd & UE; mk_v = wd & UV; mk_l = wd & UL;
        end
        @(negedge clk);
        chk("R4 edge read", rd_e, exp_read(ad, ms_e, mk_e));
        chk("R5 level read", rd_v, exp_read(ad, ms_v, mk_v));
        chk("R6 latched read", rd_l, exp_read(ad, ms_l, mk_l));
        chk("R8 edge irq", {31'd0, irq_e}, {31'd0, mi_e});
        chk("R8 level irq", {31'd0, irq_v}, {31'd0, mi_v});
        chk("R8 latched irq", {31'd0, irq_l}, {31'd0, mi_l});
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<50000 cycles", cyc);
            report();
        end
    end

    initial begin
        logic [31:0] ln;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status edge", rd_e, 32'd0);
        chk("R1 status level", rd_v, 32'd0);
        chk("R1 status latched", rd_l, 32'd0);
        chk("R1 irq", {29'd0, irq_e, irq_v, irq_l}, 32'd0);
        bus_addr = MK;
        #1;
        chk("R1 mask edge", rd_e, 32'd0);
        chk("R1 mask latched", rd_l, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {rd_e[0], irq_e, irq_v, irq_l}, 32'd0);

        // Constrained random phase
        ln = '0;
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            int unsigned r;
            ln = ln ^ ($urandom & $urandom & $urandom);
            r = $urandom % 4;
            a = (r < 2) ? ST : (r == 2) ? MK : 16'h0005;
            step(ln, ($urandom % 3) == 0, a, $urandom);
        end

        // Directed corner cases, from a known zero state
        step(32'd0, 1'b1, ST, 32'hFFFF_FFFF);
        step(32'd0, 1'b1, ST, 32'd0);
        chk("R4 flush edge", rd_e, 32'd0);
        chk("R5 flush level", rd_v, 32'd0);
        chk("R6 flush latched", rd_l, 32'd0);
        step(32'd1, 1'b0, ST, 32'd0);
        chk("R3 rise sets edge bit", rd_e, 32'd1);
        chk("R5 level follows line", rd_v, 32'd1);
        chk("R6 latched sets", rd_l, 32'd1);
        step(32'd1, 1'b1, ST, 32'd1);
        chk("R2 default mode acks with 1", rd_e, 32'd0);
        chk("R5 level write ignored", rd_v, 32'd1);
        chk("R6 latched write 1 ignored", rd_l, 32'd1);
        step(32'd1, 1'b1, ST, 32'd0);
        chk("R6 latched write 0 line high keeps", rd_l, 32'd1);
        chk("R4 edge write 0 keeps", rd_e, 32'd0);
        step(32'd0, 1'b0, ST, 32'd0);
        chk("R6 latched line low no write keeps", rd_l, 32'd1);
        chk("R5 level drops with line", rd_v, 32'd0);
        step(32'd0, 1'b1, ST, 32'd0);
        chk("R6 latched clears", rd_l, 32'd0);
        step(32'd1, 1'b1, ST, 32'd1);
        chk("R4 edge beats same-cycle ack", rd_e, 32'd1);
        step(32'd0, 1'b1, MK, 32'hFFFF_FFFF);
        chk("R7 mask readback edge", rd_e, 32'hFFFF_FFFF);
        chk("R9 mask upper zero level", rd_v, 32'h0000_00FF);
        chk("R9 mask upper zero latched", rd_l, 32'h0000_0FFF);
        step(32'd0, 1'b0, ST, 32'd0);
        chk("R8 irq from pending and enable", {31'd0, irq_e}, 32'd1);
        chk("R8 no irq level", {31'd0, irq_v}, 32'd0);
        step(32'd3, 1'b1, 16'h0007, 32'd0);
        chk("R7 other address edge", rd_e, 32'd0);
        chk("R7 other address level", rd_v, 32'd0);
        step(32'd0, 1'b0, MK, 32'd0);
        chk("R9 stray write left mask", rd_e, 32'hFFFF_FFFF);
        step(32'd0, 1'b0, MK, 32'd0);

        done = 1;
        report();
    end
endmodule